// File: doc/BRIEF.md
# Fixed-bank cartridge memory mapper

This block is the memory side of a simple game cartridge that has no bank switching. It serves two buses. The processor bus has a 16-bit address. Its upper half reaches a program ROM image. The window just below that reaches a battery-style work RAM. Everything else on this bus reads as zero. The picture bus has a 14-bit address. Its lower 8 KiB reaches pattern memory. Above that, a 2 KiB nametable RAM is reached through a selectable folding of its four logical pages.

A size flag tells the block whether the program image is small (16 KiB or less). When it is set, the upper 16 KiB window repeats the lower one. The pattern memory acts as ROM, or as RAM when no pattern image is supplied. ROM images are written through a load port. On a hard reset the work RAM is refilled with a chosen pattern, one byte per clock. While that fill runs, the processor bus is blocked. A soft reset leaves the work RAM untouched.

Each memory's stored depth is a parameter, and the defaults keep elaboration small. The program image holds 2^PRG_HALF_AW bytes for each 16 KiB half (default 1 KiB). Work RAM holds 2^WRAM_AW bytes (default 2 KiB). Pattern memory holds 2^PAT_AW bytes (default 2 KiB). Address bits above a memory's depth alias.

Top module: `cart_fixed_mapper`

## Requirements
- R1: A processor read with cpu_rd=1, cpu_wr=0 at 0x8000–0xBFFF returns, on cpu_rdata one clock later, the program byte at offset off = addr & 0x3FFF. A program offset off is stored at index {off[14], off[PRG_HALF_AW-1:0]}.
- R2: A processor read at 0xC000–0xFFFF uses off = addr & 0x3FFF when cfg_prg_small=1, and off = addr & 0x7FFF when cfg_prg_small=0.
- R3: Processor reads and writes at 0x6000–0x7FFF reach work RAM at index addr[WRAM_AW-1:0]. A write is visible to the next read.
- R4: Processor writes outside 0x6000–0x7FFF change nothing. Processor reads at 0x0000–0x5FFF return 0x00.
- R5: Picture-bus accesses at 0x0000–0x1FFF reach pattern memory at index addr[PAT_AW-1:0]. Picture-bus writes there take effect only when cfg_pat_ram=1.
- R6: Picture-bus accesses at 0x2000–0x3EFF reach a 2 KiB nametable RAM at index {m, addr[9:0]}. Here m = addr[10] when cfg_mirror_h=0 (vertical) and m = addr[11] when cfg_mirror_h=1 (horizontal).
- R7: Picture-bus reads at 0x3F00–0x3FFF return 0x00, and picture-bus writes there change nothing.
- R8: When rst is high with rst_hard=1, wram_busy is high and work RAM is filled after rst falls. The fill writes index 0 upward, one byte per clock, for 2^WRAM_AW clocks. fill_mode 01 writes 0xFF. fill_mode 10 writes the state s of an 8-bit shift register and then steps it: s starts at LFSR_SEED (default 0x01), and the next s is {s[6:0], s[7]^s[5]^s[4]^s[3]}. Any other fill_mode writes 0x00.
- R9: A reset with rst_hard=0 leaves work RAM contents unchanged and wram_busy low.
- R10: While wram_busy is high, processor reads return 0x00 and processor writes change nothing. The picture bus is unaffected.
- R11: A cycle with both read and write strobes on one bus is a write only, and that bus's read data keeps its value.
- R12: With ld_we=1, ld_data is stored at program offset ld_addr when ld_pat=0, and at pattern index ld_addr[PAT_AW-1:0] when ld_pat=1. A load takes priority over a picture-bus write in the same cycle.
- R13: cpu_rdata and ppu_rdata are 0x00 while rst is high, change only after a read-only cycle, and otherwise hold. Bus strobes are ignored while rst is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_hard | input | 1 | Marks the reset as hard, which starts a work RAM fill |
| fill_mode | input | 2 | Work RAM fill pattern select |
| cfg_prg_small | input | 1 | Program image is 16 KiB or smaller |
| cfg_pat_ram | input | 1 | Pattern memory is writable RAM |
| cfg_mirror_h | input | 1 | Nametable folding: 1 horizontal, 0 vertical |
| ld_we | input | 1 | Image load strobe |
| ld_pat | input | 1 | Load target: 1 pattern, 0 program |
| ld_addr | input | 15 | Load offset |
| ld_data | input | 8 | Load byte |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte, registered |
| wram_busy | output | 1 | Work RAM fill in progress |
| ppu_rd | input | 1 | Picture-bus read strobe |
| ppu_wr | input | 1 | Picture-bus write strobe |
| ppu_addr | input | 14 | Picture-bus address |
| ppu_wdata | input | 8 | Picture-bus write byte |
| ppu_rdata | output | 8 | Picture-bus read byte, registered |

## Verification
The bound checker checks a set of properties on every cycle. Processor reads below 0x6000 must return zero, and picture-bus reads at 0x3F00 and above must return zero. Read data must hold across write cycles and across idle cycles on the processor bus. Every read made while wram_busy is high must return zero. The checker cannot see stored contents, so it cannot show any of the following: that the upper program window mirrors the lower one, that the nametable pages fold as configured, or that pattern writes are gated by cfg_pat_ram. It also cannot show the fill sequence for each mode, or that work RAM survives a soft reset. Only the bench's reference model can show these, by comparing every read against the bytes it tracks.

// File: rtl/cart_fixed_mapper.sv
module cart_fixed_mapper #(
  parameter int PRG_HALF_AW = 10,
  parameter int WRAM_AW = 11,
  parameter int PAT_AW = 11,
  parameter logic [7:0] LFSR_SEED = 8'h01
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rst_hard,
  input  logic [1:0]  fill_mode,
  input  logic        cfg_prg_small,
  input  logic        cfg_pat_ram,
  input  logic        cfg_mirror_h,
  input  logic        ld_we,
  input  logic        ld_pat,
  input  logic [14:0] ld_addr,
  input  logic [7:0]  ld_data,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        wram_busy,
  input  logic        ppu_rd,
  input  logic        ppu_wr,
  input  logic [13:0] ppu_addr,
  input  logic [7:0]  ppu_wdata,
  output logic [7:0]  ppu_rdata
);
  localparam int PRG_DEPTH  = 2 ** (PRG_HALF_AW + 1);
  localparam int WRAM_DEPTH = 2 ** WRAM_AW;
  localparam int PAT_DEPTH  = 2 ** PAT_AW;
  localparam int NT_DEPTH   = 2048;

  logic [7:0] prg_mem [PRG_DEPTH];
  logic [7:0] wram    [WRAM_DEPTH];
  logic [7:0] pat_mem [PAT_DEPTH];
  logic [7:0] nt_mem  [NT_DEPTH];

  logic [WRAM_AW-1:0] fill_ptr;
  logic [7:0] lfsr, lfsr_next, fill_byte;
  logic [7:0] cpu_val, ppu_val;

  wire cpu_in_rom  = cpu_addr[15];
  wire cpu_in_ram  = cpu_addr[15:13] == 3'b011;
  wire cpu_rd_only = cpu_rd & ~cpu_wr;
  wire ppu_rd_only = ppu_rd & ~ppu_wr;

  wire [14:0] rom_off = {cpu_addr[14] & ~cfg_prg_small, cpu_addr[13:0]};
  wire [PRG_HALF_AW:0] rom_idx = {rom_off[14], rom_off[PRG_HALF_AW-1:0]};
  wire [PRG_HALF_AW:0] ld_prg_idx = {ld_addr[14], ld_addr[PRG_HALF_AW-1:0]};
  wire [WRAM_AW-1:0] ram_idx = cpu_addr[WRAM_AW-1:0];

  wire ppu_in_pat = ~ppu_addr[13];
  wire ppu_in_nt  = ppu_addr[13] & (ppu_addr[12:8] != 5'h1F);
  wire [10:0] nt_idx = {cfg_mirror_h ? ppu_addr[11] : ppu_addr[10], ppu_addr[9:0]};
  wire [PAT_AW-1:0] pat_idx = ppu_addr[PAT_AW-1:0];

  logic unused_bits;
  assign unused_bits = ^{rom_off[13:PRG_HALF_AW], ld_addr[13:PAT_AW]};

  assign lfsr_next = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always_comb begin
    case (fill_mode)
      2'b01:   fill_byte = 8'hFF;
      2'b10:   fill_byte = lfsr;
      default: fill_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wram_busy <= rst_hard;
      fill_ptr  <= '0;
      lfsr      <= LFSR_SEED;
    end else if (wram_busy) begin
      fill_ptr <= fill_ptr + 1'b1;
      lfsr     <= lfsr_next;
      if (&fill_ptr) wram_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (wram_busy) wram[fill_ptr] <= fill_byte;
      else if (cpu_wr && cpu_in_ram) wram[ram_idx] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_we && !ld_pat) prg_mem[ld_prg_idx] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_we && ld_pat) pat_mem[ld_addr[PAT_AW-1:0]] <= ld_data;
    else if (!rst && ppu_wr && ppu_in_pat && cfg_pat_ram) pat_mem[pat_idx] <= ppu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst && ppu_wr && ppu_in_nt) nt_mem[nt_idx] <= ppu_wdata;
  end

  always_comb begin
    if (wram_busy)       cpu_val = 8'h00;
    else if (cpu_in_rom) cpu_val = prg_mem[rom_idx];
    else if (cpu_in_ram) cpu_val = wram[ram_idx];
    else                 cpu_val = 8'h00;
  end

  always_comb begin
    if (ppu_in_pat)     ppu_val = pat_mem[pat_idx];
    else if (ppu_in_nt) ppu_val = nt_mem[nt_idx];
    else                ppu_val = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= 8'h00;
      ppu_rdata <= 8'h00;
    end else begin
      if (cpu_rd_only) cpu_rdata <= cpu_val;
      if (ppu_rd_only) ppu_rdata <= ppu_val;
    end
  end
endmodule

// File: rtl/cart_fixed_mapper_chk.sv
module cart_fixed_mapper_chk (
  input logic        clk,
  input logic        rst,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_rdata,
  input logic        wram_busy,
  input logic        ppu_rd,
  input logic        ppu_wr,
  input logic [13:0] ppu_addr,
  input logic [7:0]  ppu_rdata
);
  a_r4_unmapped_cpu_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_addr < 16'h6000) |=> cpu_rdata == 8'h00);

  a_r7_ppu_high_zero: assert property (@(posedge clk) disable iff (rst)
    (ppu_rd && !ppu_wr && ppu_addr[13:8] == 6'h3F) |=> ppu_rdata == 8'h00);

  a_r10_busy_blocks_read: assert property (@(posedge clk) disable iff (rst)
    (wram_busy && cpu_rd) |=> cpu_rdata == 8'h00);

  a_r11_cpu_write_wins: assert property (@(posedge clk) disable iff (rst)
    cpu_wr |=> $stable(cpu_rdata));

  a_r11_ppu_write_wins: assert property (@(posedge clk) disable iff (rst)
    ppu_wr |=> $stable(ppu_rdata));

  a_r13_cpu_hold: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata));

  a_r13_ppu_hold: assert property (@(posedge clk) disable iff (rst)
    !ppu_rd |=> $stable(ppu_rdata));
endmodule

bind cart_fixed_mapper cart_fixed_mapper_chk u_chk (
  .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_rdata(cpu_rdata), .wram_busy(wram_busy), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr),
  .ppu_addr(ppu_addr), .ppu_rdata(ppu_rdata)
);

// File: tb/cart_fixed_mapper_test.sv
module cart_fixed_mapper_test;
  localparam int HALF = 1024;
  localparam int WDEPTH = 2048;
  localparam int PDEPTH = 2048;

  logic clk = 0;
  always #2 clk = ~clk;

  logic rst, rst_hard, cfg_prg_small, cfg_pat_ram, cfg_mirror_h;
  logic [1:0] fill_mode;
  logic ld_we, ld_pat;
  logic [14:0] ld_addr;
  logic [7:0] ld_data;
  logic cpu_rd, cpu_wr, ppu_rd, ppu_wr, wram_busy;
  logic [15:0] cpu_addr;
  logic [13:0] ppu_addr;
  logic [7:0] cpu_wdata, cpu_rdata, ppu_wdata, ppu_rdata;

  cart_fixed_mapper uut (
    .clk(clk), .rst(rst), .rst_hard(rst_hard), .fill_mode(fill_mode),
    .cfg_prg_small(cfg_prg_small), .cfg_pat_ram(cfg_pat_ram), .cfg_mirror_h(cfg_mirror_h),
    .ld_we(ld_we), .ld_pat(ld_pat), .ld_addr(ld_addr), .ld_data(ld_data),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .wram_busy(wram_busy),
    .ppu_rd(ppu_rd), .ppu_wr(ppu_wr), .ppu_addr(ppu_addr), .ppu_wdata(ppu_wdata),
    .ppu_rdata(ppu_rdata)
  );

  int total = 0, bad = 0;
  bit started = 0;

  logic [7:0] m_prg [int];
  logic [7:0] m_wram [int];
  logic [7:0] m_pat [int];
  logic [7:0] m_nt [int];
  logic [7:0] e_cpu, e_ppu, m_lfsr;
  bit k_cpu, k_ppu, m_busy;
  int m_ptr;
  string t_cpu, t_ppu, ram_tag;

  function automatic int prg_i(int off);
    return ((off >> 14) & 1) * HALF + (off % HALF);
  endfunction

  function automatic int nt_i(int a, bit horiz);
    int m;
    m = horiz ? ((a >> 11) & 1) : ((a >> 10) & 1);
    return m * 1024 + (a & 16'h3FF);
  endfunction

  // behavioural reference model, updated on every rising edge
  always @(posedge clk) begin
    int a, off;
    logic [7:0] fb;
    if (rst) begin
      e_cpu = 0; k_cpu = 1; t_cpu = "R13";
      e_ppu = 0; k_ppu = 1; t_ppu = "R13";
      m_busy = rst_hard; m_ptr = 0; m_lfsr = 8'h01;
    end else begin
      if (cpu_rd && cpu_wr) t_cpu = "R11";
      else if (!cpu_rd) t_cpu = "R13";
      else begin
        a = int'(cpu_addr);
        k_cpu = 1;
        if (m_busy) begin e_cpu = 0; t_cpu = "R10"; end
        else if (a >= 16'h8000) begin
          if (a >= 16'hC000) begin
            off = cfg_prg_small ? (a & 16'h3FFF) : (a & 16'h7FFF); t_cpu = "R2";
          end else begin
            off = a & 16'h3FFF; t_cpu = "R1";
          end
          if (m_prg.exists(prg_i(off))) e_cpu = m_prg[prg_i(off)]; else k_cpu = 0;
        end else if (a >= 16'h6000) begin
          t_cpu = ram_tag;
          if (m_wram.exists(a % WDEPTH)) e_cpu = m_wram[a % WDEPTH]; else k_cpu = 0;
        end else begin e_cpu = 0; t_cpu = "R4"; end
      end
      if (ppu_rd && ppu_wr) t_ppu = "R11";
      else if (!ppu_rd) t_ppu = "R13";
      else begin
        a = int'(ppu_addr);
        k_ppu = 1;
        if (a < 16'h2000) begin
          t_ppu = "R5";
          if (m_pat.exists(a % PDEPTH)) e_ppu = m_pat[a % PDEPTH]; else k_ppu = 0;
        end else if (a < 16'h3F00) begin
          t_ppu = "R6";
          if (m_nt.exists(nt_i(a, cfg_mirror_h))) e_ppu = m_nt[nt_i(a, cfg_mirror_h)]; else k_ppu = 0;
        end else begin e_ppu = 0; t_ppu = "R7"; end
      end
      if (m_busy) begin
        fb = (fill_mode == 2'b01) ? 8'hFF : (fill_mode == 2'b10) ? m_lfsr : 8'h00;
        m_wram[m_ptr] = fb;
        m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
        if (m_ptr == WDEPTH - 1) m_busy = 0;
        m_ptr++;
      end else if (cpu_wr && cpu_addr >= 16'h6000 && cpu_addr < 16'h8000)
        m_wram[int'(cpu_addr) % WDEPTH] = cpu_wdata;
      if (ppu_wr) begin
        a = int'(ppu_addr);
        if (a < 16'h2000 && cfg_pat_ram) m_pat[a % PDEPTH] = ppu_wdata;
        else if (a >= 16'h2000 && a < 16'h3F00) m_nt[nt_i(a, cfg_mirror_h)] = ppu_wdata;
      end
    end
    if (ld_we) begin
      if (ld_pat) m_pat[int'(ld_addr) % PDEPTH] = ld_data;
      else m_prg[prg_i(int'(ld_addr))] = ld_data;
    end
    started = 1;
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      if (k_cpu) check(cpu_rdata === e_cpu, t_cpu, "cpu_rdata", int'(cpu_rdata), int'(e_cpu));
      if (k_ppu) check(ppu_rdata === e_ppu, t_ppu, "ppu_rdata", int'(ppu_rdata), int'(e_ppu));
      check(wram_busy === m_busy, "R10", "wram_busy", int'(wram_busy), int'(m_busy));
    end
  end

  task automatic idle();
    cpu_rd = 0; cpu_wr = 0; ppu_rd = 0; ppu_wr = 0; ld_we = 0;
  endtask
  task automatic tick(int n);
    repeat (n) begin @(negedge clk); idle(); end
  endtask
  task automatic cpu_read(logic [15:0] a);
    @(negedge clk); idle(); cpu_rd = 1; cpu_addr = a;
  endtask
  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); idle(); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
  endtask
  task automatic ppu_read(logic [13:0] a);
    @(negedge clk); idle(); ppu_rd = 1; ppu_addr = a;
  endtask
  task automatic ppu_write(logic [13:0] a, logic [7:0] d);
    @(negedge clk); idle(); ppu_wr = 1; ppu_addr = a; ppu_wdata = d;
  endtask
  task automatic load(bit pat, logic [14:0] a, logic [7:0] d);
    @(negedge clk); idle(); ld_we = 1; ld_pat = pat; ld_addr = a; ld_data = d;
  endtask
  task automatic do_reset(bit hard, logic [1:0] mode);
    @(negedge clk); idle(); rst = 1; rst_hard = hard; fill_mode = mode;
    tick(2);
    rst = 0;
    tick(1);
    while (wram_busy) tick(1);
    tick(1);
  endtask

  initial begin
    idle(); rst = 1; rst_hard = 1; fill_mode = 2'b01; ram_tag = "R8";
    cfg_prg_small = 1; cfg_pat_ram = 0; cfg_mirror_h = 0;
    ld_pat = 0; ld_addr = 0; ld_data = 0; cpu_addr = 0; cpu_wdata = 0;
    ppu_addr = 0; ppu_wdata = 0;
    tick(3);  // R13 reset state checked each cycle
    rst = 0;
    // R10: accesses while the fill runs
    cpu_read(16'h6000); cpu_write(16'h6010, 8'h55); cpu_read(16'h6010);
    tick(1);
    while (wram_busy) tick(1);
    tick(1);
    // R8: fill with ones; the blocked write must not have landed
    cpu_read(16'h6000); cpu_read(16'h6010); cpu_read(16'h67FF); tick(1);
    // R12: program image load, both halves
    for (int i = 0; i < 8; i++) begin
      load(0, 15'(i), 8'h10 + 8'(i));
      load(0, 15'h4000 + 15'(i), 8'hA0 + 8'(i));
    end
    // R1 / R2 small image mirrors
    cpu_read(16'h8003); cpu_read(16'hC003); cpu_read(16'hFC07); tick(1);
    cfg_prg_small = 0;
    cpu_read(16'hC003); cpu_read(16'h8005); cpu_read(16'hC000); tick(1);
    // R3 work RAM, including alias at +0x800
    ram_tag = "R3";
    cpu_write(16'h6021, 8'h3C); cpu_write(16'h7FFF, 8'h99);
    cpu_read(16'h6021); cpu_read(16'h6821); cpu_read(16'h67FF); tick(1);
    // R4 writes outside the RAM window ignored, low reads zero
    cpu_write(16'h8003, 8'hEE); cpu_write(16'h5000, 8'hEE); cpu_write(16'h0021, 8'hEE);
    cpu_read(16'h8003); cpu_read(16'h5000); cpu_read(16'h0021); cpu_read(16'h6021); tick(1);
    // R11 write and read together on the processor bus
    cpu_read(16'h8004);
    @(negedge clk); idle(); cpu_rd = 1; cpu_wr = 1; cpu_addr = 16'h6021; cpu_wdata = 8'h77;
    tick(2); cpu_read(16'h6021); tick(2);  // R13 hold over idle cycles
    // R5 / R12 pattern ROM: load, then gated write
    load(1, 15'h0040, 8'h5A); load(1, 15'h0041, 8'h6B);
    ppu_write(14'h0040, 8'hFF); ppu_read(14'h0040); ppu_read(14'h0041);
    cfg_pat_ram = 1;
    ppu_write(14'h0041, 8'hC3); ppu_read(14'h0041); ppu_read(14'h0841); tick(1);
    // R12 load wins over same-cycle picture write
    @(negedge clk); idle(); ld_we = 1; ld_pat = 1; ld_addr = 15'h0050; ld_data = 8'h12;
    ppu_wr = 1; ppu_addr = 14'h0050; ppu_wdata = 8'h34;
    ppu_read(14'h0050); tick(1);
    // R6 vertical folding
    cfg_mirror_h = 0;
    ppu_write(14'h2000, 8'hAA); ppu_write(14'h2400, 8'hBB);
    ppu_read(14'h2800); ppu_read(14'h2C00); ppu_read(14'h3400); tick(1);
    // R6 horizontal folding
    cfg_mirror_h = 1;
    ppu_write(14'h2000, 8'h11); ppu_write(14'h2800, 8'h22);
    ppu_read(14'h2400); ppu_read(14'h2C00); tick(1);
    // R7 top range reads zero, write there leaves nametable alone
    cfg_mirror_h = 0;
    ppu_write(14'h2705, 8'h44);
    ppu_write(14'h3F05, 8'h99); ppu_read(14'h3F05); ppu_read(14'h2705); tick(1);
    // R11 on the picture bus
    @(negedge clk); idle(); ppu_rd = 1; ppu_wr = 1; ppu_addr = 14'h2705; ppu_wdata = 8'h66;
    tick(1); ppu_read(14'h2705); tick(1);
    // R9 soft reset keeps work RAM
    do_reset(0, 2'b01);
    ram_tag = "R9";
    cpu_read(16'h6021); cpu_read(16'h7FFF); tick(1);
    // R8 pseudo-random fill and zero fill
    do_reset(1, 2'b10);
    ram_tag = "R8";
    for (int i = 0; i < 5; i++) cpu_read(16'h6000 + 16'(i));
    cpu_read(16'h67FF); tick(1);
    do_reset(1, 2'b00);
    cpu_read(16'h6021); cpu_read(16'h6003); tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule